// File: doc/BRIEF.md
# Rotating Two-Deep Section Shift Register

This block is a fixed-depth word shift register. Its storage is split into `WAYS` sections, each two words deep. The sections are served one after another in a fixed rotation. When a section is visited it does three things in order. First it offers its output-side word on the output channel. Next it moves its input-side word to the output side in one internal cycle. Last it takes one new word from the input channel. The next section is then visited.

Both channels use valid/ready handshakes. The input channel is passive: the block raises `in_ready`. The output channel is active: the block raises `out_valid`. Each round emits a word before it accepts one, so the block behaves as a register and not as a FIFO. The `2*WAYS` words loaded at reset leave the block before any input word does. After them, the output stream is the input stream delayed by exactly `2*WAYS` words.

With `WAYS = 4` the block holds 8 places. With `WAYS = 2` it holds 4 places. Each step costs only the time of a two-place stage, whatever the total depth.

Top module: `wag_shift_reg`

## Requirements
- R1: After reset is released, `out_valid` is 1, `in_ready` is 0 and `out_data` is 0.
- R2: `out_valid` and `in_ready` are never 1 in the same cycle.
- R3: Each round follows a fixed order. First, an output transfer completes (`out_valid` and `out_ready` both 1). In the next cycle both `out_valid` and `in_ready` are 0. In the cycle after that, `in_ready` is 1 and stays 1 until an input transfer completes. In the cycle after the input transfer, `out_valid` is 1.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change in the next cycle.
- R5: All storage resets to zero, so the first `2*WAYS` output words are 0.
- R6: After those zero words, output word number k+`2*WAYS` equals input word number k. Words are counted in the order of their completed transfers.
- R7: An asserted `in_valid` in a cycle where `in_ready` is 0 transfers nothing. Neither the word order nor the delay of R6 is disturbed by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Block accepts a word in this cycle |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Block offers a word on `out_data` |
| out_ready | input | 1 | Consumer takes the offered word |
| out_data | output | DATA_W | Output word |

## Verification
In many cycles an offered input word and an offered output word are present at the same time: the producer holds `in_valid` high while the block is in its send or internal-shift step. The bench provokes this by keeping `in_valid` asserted without a break for a long stretch, and also by random toggling. Alongside that it applies random back-pressure on `out_ready`, and one long stall. A behavioural queue model, preloaded with the reset zeros, is compared with the ports on every cycle. The comparison covers that the early input is not taken, that only one channel is open per cycle, and that every emitted word matches the word delayed by the full depth.

// File: rtl/wag_pkg.sv
package wag_pkg;
   // Step of the section currently being served
   typedef enum logic [1:0] {
      ST_SEND  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_RECV  = 2'd2
   } wag_step_e;
endpackage

// File: rtl/wag_sequencer.sv
module wag_sequencer
   import wag_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             out_ready,
   input  logic             in_valid,
   output logic             out_valid,
   output logic             in_ready,
   output logic             shift_en,
   output logic             load_en,
   output logic [IDX_W-1:0] sel
);
   localparam logic [IDX_W-1:0] LAST_SEL = IDX_W'(WAYS - 1);

   wag_step_e step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_SEND;
         sel    <= '0;
      end else begin
         unique case (step_q)
            ST_SEND:  if (out_ready) step_q <= ST_SHIFT;
            ST_SHIFT: step_q <= ST_RECV;
            ST_RECV: begin
               if (in_valid) begin
                  step_q <= ST_SEND;
                  sel    <= (sel == LAST_SEL) ? '0 : sel + 1'b1;
               end
            end
            default:  step_q <= ST_SEND;
         endcase
      end
   end

   assign out_valid = (step_q == ST_SEND);
   assign in_ready  = (step_q == ST_RECV);
   assign shift_en  = (step_q == ST_SHIFT);
   assign load_en   = in_ready && in_valid;
endmodule

// File: rtl/wag_section.sv
module wag_section #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              load_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] near_q;   // input-side word
   logic [DATA_W-1:0] far_q;    // output-side word

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         near_q <= '0;
         far_q  <= '0;
      end else begin
         if (shift_en) far_q  <= near_q;
         if (load_en)  near_q <= din;
      end
   end

   assign dout = far_q;
endmodule

// File: rtl/wag_out_select.sv
module wag_out_select #(
   parameter int DATA_W = 8,
   parameter int WAYS   = 4,
   parameter int IDX_W  = 2
) (
   input  logic [WAYS-1:0][DATA_W-1:0] words,
   input  logic [IDX_W-1:0]            sel,
   output logic [DATA_W-1:0]           word_o
);
   always_comb begin
      word_o = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (sel == IDX_W'(i)) word_o = words[i];
      end
   end
endmodule

// File: rtl/wag_shift_reg.sv
module wag_shift_reg #(
   parameter int DATA_W = 8,
   parameter int WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   generate
      if (!(WAYS == 2 || WAYS == 4)) begin : g_bad_ways
         $error("wag_shift_reg: WAYS must be 2 or 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("wag_shift_reg: DATA_W must be at least 1");
      end
   endgenerate

   logic                       shift_en;
   logic                       load_en;
   logic [IDX_W-1:0]           sel;
   logic [WAYS-1:0][DATA_W-1:0] far_words;

   wag_sequencer #(.WAYS(WAYS), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_ready (out_ready),
      .in_valid  (in_valid),
      .out_valid (out_valid),
      .in_ready  (in_ready),
      .shift_en  (shift_en),
      .load_en   (load_en),
      .sel       (sel)
   );

   for (genvar g = 0; g < WAYS; g++) begin : g_sect
      logic hit;
      assign hit = (sel == IDX_W'(g));
      wag_section #(.DATA_W(DATA_W)) u_sect (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (shift_en && hit),
         .load_en  (load_en && hit),
         .din      (in_data),
         .dout     (far_words[g])
      );
   end

   wag_out_select #(.DATA_W(DATA_W), .WAYS(WAYS), .IDX_W(IDX_W)) u_osel (
      .words  (far_words),
      .sel    (sel),
      .word_o (out_data)
   );
endmodule

// File: rtl/wag_shift_reg_chk.sv
module wag_shift_reg_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   p_one_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && in_ready));

   p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_gap_after_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid && !in_ready));

   p_recv_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !in_ready) |=> in_ready);

   p_wait_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> in_ready);

   p_send_after_recv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> out_valid);
endmodule

bind wag_shift_reg wag_shift_reg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/wag_shift_reg_tb.sv
module wag_shift_reg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int WAYS       = 4;
   localparam int DEPTH      = 2 * WAYS;
   localparam int WATCHDOG   = 50000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   // behavioural reference: phase 0 emit, 1 gap, 2 accept
   int         m_phase = 0;
   logic [DATA_W-1:0] m_q[$];
   int         outs_seen = 0;
   logic [DATA_W-1:0] prev_data = '0;
   bit         prev_stall = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wag_shift_reg #(.DATA_W(DATA_W), .WAYS(WAYS)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // model update on the edge; inputs are stable since the previous falling edge
   always @(posedge clk) begin
      if (rst_n) begin
         cycles++;
         case (m_phase)
            0: if (out_ready) begin
                  void'(m_q.pop_front());
                  outs_seen++;
                  m_phase = 1;
               end
            1: m_phase = 2;
            default: if (in_valid) begin
                  m_q.push_back(in_data);
                  m_phase = 0;
               end
         endcase
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(out_valid == (m_phase == 0), "R2/R3 out_valid", out_valid, m_phase == 0);
         check(in_ready == (m_phase == 2), "R2/R3/R7 in_ready", in_ready, m_phase == 2);
         if (m_phase == 0 && out_valid) begin
            if (outs_seen < DEPTH)
               check(out_data == 0, "R5 reset word", out_data, 0);
            else
               check(out_data == m_q[0], "R6 delayed word", out_data, m_q[0]);
         end
         if (prev_stall)
            check(out_valid && out_data == prev_data, "R4 stall hold", out_data, prev_data);
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) m_q.push_back('0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: state right after reset release
      check(out_valid == 1'b1, "R1 out_valid", out_valid, 1);
      check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
      check(out_data == 0, "R1 out_data", out_data, 0);

      // R7: in_valid held high continuously, sink always ready
      for (int c = 0; c < 300; c++) begin
         in_valid  = 1'b1;
         out_ready = 1'b1;
         in_data   = DATA_W'(c * 7 + 3);
         @(negedge clk);
      end
      // random producer and consumer
      for (int c = 0; c < 3000; c++) begin
         in_valid  = ($urandom % 3) != 0;
         out_ready = ($urandom % 4) != 0;
         in_data   = DATA_W'($urandom);
         @(negedge clk);
      end
      // R4: long consumer stall with producer active
      out_ready = 1'b0;
      in_valid  = 1'b1;
      for (int c = 0; c < 40; c++) begin
         in_data = DATA_W'($urandom);
         @(negedge clk);
      end
      out_ready = 1'b1;
      for (int c = 0; c < 200; c++) begin
         in_valid = ($urandom % 2) != 0;
         in_data  = DATA_W'($urandom);
         @(negedge clk);
      end
      check(outs_seen > 3 * DEPTH, "R6 progress", outs_seen, 3 * DEPTH);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule